// File: doc/BRIEF.md
# DVFS Frequency Change Sequencer

This block moves the chip from one performance level to another. Each of the eight levels pairs a core and memory clock setting with a supply voltage, and both rise with the level index. A request names the target level. The sequencer then stops all outside traffic and all memory access, reprograms the clock multipliers, holds the clocks off while the PLL relocks, and brings the system back up in reverse order. It also moves the regulator voltage at the correct point and waits for the supply to settle.

Every partner block is reached through a plain request/acknowledge pair: the write buffers (drain), the bus arbiter (forced grant), the memory controller (self-refresh) and the clock unit (stop and multiplier load). All waits are counted in microseconds on the block clock, using a parameter that gives the number of clock ticks per microsecond. A single countdown timer serves every wait. The policy that picks a level is outside this block.

When the level rises, the voltage is raised and allowed to settle before any clock change. When the level falls, the clocks change first and the voltage is lowered at the end. A request for the level that is already active completes at once.

Top module: `dvfs_seq`

## Requirements
- R1: After reset, cur_level, mult_level and vreg_level are 0, clk_stop, force_grant, self_refresh, wr_flush_req, busy, done and hs_error are all 0.
- R2: A request whose level equals cur_level pulses done one cycle after it is sampled, and busy, wr_flush_req and force_grant stay 0.
- R3: For a change, wr_flush_req is held until wr_flush_ack. force_grant then rises, and self_refresh rises only after grant_ack. After sr_ack, mult_load pulses for one cycle with mult_level equal to the target. clk_stop rises after that pulse.
- R4: clk_stop stays high for max(cfg_relock_us, MIN_RELOCK_US) microseconds (MIN_RELOCK_US = 10), counted as that many times TICKS_PER_US cycles, plus at most two cycles.
- R5: After clk_stop falls, self_refresh falls. force_grant falls only after sr_ack is low. done pulses only after grant_ack is low, and cur_level takes the target in the cycle that done is high.
- R6: On a rise, vreg_level takes the target before wr_flush_req rises, and the gap between the two is cfg_settle_us times TICKS_PER_US cycles, plus at most two cycles.
- R7: On a fall, vreg_level changes only after grant_ack is low, and done follows after cfg_settle_us times TICKS_PER_US cycles, plus at most two cycles.
- R8: vreg_level is never below mult_level.
- R9: If an acknowledge for force-grant, self-refresh entry, self-refresh exit or grant release takes more than HS_MAX_US microseconds, hs_error is set. The sequence still completes once the acknowledge comes. hs_error stays set until the next change is accepted. An acknowledge within the limit leaves hs_error at 0.
- R10: While busy is high, req_valid is ignored. busy stays high until done, and the final level is the first target.
- R11: A settle time of 256 us is accepted in the 16-bit cfg_settle_us and is honoured in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the time reference for all waits |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Level change request, sampled while idle |
| req_level | input | LVL_W | Target level of the request |
| cfg_relock_us | input | US_W | PLL relock wait in microseconds (raised to the minimum) |
| cfg_settle_us | input | US_W | Regulator settle wait in microseconds |
| wr_flush_req | output | 1 | Ask the write buffers to drain |
| wr_flush_ack | input | 1 | Write buffers are empty |
| force_grant | output | 1 | Ask the arbiter to park the bus on the processor |
| grant_ack | input | 1 | Arbiter has parked the bus (level) |
| self_refresh | output | 1 | Ask memory to enter self-refresh (level) |
| sr_ack | input | 1 | Memory is in self-refresh (level) |
| mult_load | output | 1 | One-cycle strobe that loads the new multiplier/divisor set |
| mult_level | output | LVL_W | Level whose multiplier/divisor set is loaded |
| clk_stop | output | 1 | Clocks gated while the PLL relocks |
| vreg_level | output | LVL_W | Voltage level given to the regulator |
| cur_level | output | LVL_W | Level now in force |
| busy | output | 1 | A change is in progress |
| done | output | 1 | One-cycle pulse when a request completes |
| hs_error | output | 1 | An acknowledge came after the handshake limit |

## Verification
The bench builds the block with TICKS_PER_US = 2 and keeps MIN_RELOCK_US = 10 and HS_MAX_US = 2. With these values a microsecond is two cycles, so the relock floor, the full 256 us settle and a late acknowledge all fit in a short run, and window widths can be checked to the cycle. The default handshake limit is only four cycles. This lets the bench's acknowledge responders move from inside the limit to well past it by changing a single delay.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_VUP,
        ST_FLUSH,
        ST_GRANT,
        ST_SRIN,
        ST_LOAD,
        ST_STOP,
        ST_RESUME,
        ST_SROUT,
        ST_REL,
        ST_VDN
    } seq_state_e;

endpackage

// File: rtl/dvfs_timer.sv
module dvfs_timer #(
    parameter int TICKS_PER_US = 50,
    parameter int US_W         = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [US_W-1:0] load_us_i,
    output logic            expired_o
);
    localparam int PRE_W = (TICKS_PER_US > 1) ? $clog2(TICKS_PER_US) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS_PER_US - 1);

    logic [PRE_W-1:0] pre_d, pre_q;
    logic [US_W-1:0]  cnt_d, cnt_q;

    always_comb begin
        pre_d = pre_q;
        cnt_d = cnt_q;
        if (load_i) begin
            pre_d = '0;
            cnt_d = load_us_i;
        end else if (cnt_q != '0) begin
            if (pre_q == PRE_LAST) begin
                pre_d = '0;
                cnt_d = cnt_q - 1'b1;
            end else begin
                pre_d = pre_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else begin
            pre_q <= pre_d;
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = (cnt_q == '0);

    // R4: the microsecond count never grows unless reloaded
    a_r4_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> cnt_q <= $past(cnt_q));

    // R4: the tick prescaler stays inside one microsecond
    a_r4_pre_bound: assert property (@(posedge clk) disable iff (!rst_n)
        32'(pre_q) < TICKS_PER_US);

endmodule

// File: rtl/dvfs_ctrl.sv
module dvfs_ctrl
    import dvfs_pkg::*;
#(
    parameter int LVL_W         = 3,
    parameter int US_W          = 16,
    parameter int TICKS_PER_US  = 50,
    parameter int MIN_RELOCK_US = 10,
    parameter int HS_MAX_US     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid_i,
    input  logic [LVL_W-1:0] req_level_i,
    input  logic [US_W-1:0]  cfg_relock_us_i,
    input  logic [US_W-1:0]  cfg_settle_us_i,
    input  logic             flush_ack_i,
    input  logic             grant_ack_i,
    input  logic             sr_ack_i,
    input  logic             tmr_expired_i,
    output logic             tmr_load_o,
    output logic [US_W-1:0]  tmr_us_o,
    output logic             flush_o,
    output logic             fgrant_o,
    output logic             sr_o,
    output logic             mload_o,
    output logic [LVL_W-1:0] mlev_o,
    output logic             clkstop_o,
    output logic [LVL_W-1:0] vreg_o,
    output logic [LVL_W-1:0] cur_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o
);
    localparam logic [US_W-1:0] HS_US  = US_W'(HS_MAX_US);
    localparam logic [US_W-1:0] MIN_US = US_W'(MIN_RELOCK_US);

    typedef struct packed {
        seq_state_e       st;
        logic [LVL_W-1:0] tgt;
        logic [LVL_W-1:0] cur;
        logic [LVL_W-1:0] vreg;
        logic [LVL_W-1:0] mlev;
        logic             flush;
        logic             fgrant;
        logic             sr;
        logic             clkstop;
        logic             mload;
        logic             busy;
        logic             done;
        logic             err;
    } ctrl_t;

    ctrl_t d, q;
    logic [US_W-1:0] relock_us;

    assign relock_us = (cfg_relock_us_i < MIN_US) ? MIN_US : cfg_relock_us_i;

    always_comb begin
        d          = q;
        d.done     = 1'b0;
        d.mload    = 1'b0;
        tmr_load_o = 1'b0;
        tmr_us_o   = HS_US;
        unique case (q.st)
            ST_IDLE: if (req_valid_i) begin
                if (req_level_i == q.cur) begin
                    d.done = 1'b1;
                end else begin
                    d.busy = 1'b1;
                    d.err  = 1'b0;
                    d.tgt  = req_level_i;
                    if (req_level_i > q.cur) begin
                        d.st       = ST_VUP;
                        d.vreg     = req_level_i;
                        tmr_load_o = 1'b1;
                        tmr_us_o   = cfg_settle_us_i;
                    end else begin
                        d.st    = ST_FLUSH;
                        d.flush = 1'b1;
                    end
                end
            end
            ST_VUP: if (tmr_expired_i) begin
                d.st    = ST_FLUSH;
                d.flush = 1'b1;
            end
            ST_FLUSH: if (flush_ack_i) begin
                d.flush    = 1'b0;
                d.fgrant   = 1'b1;
                d.st       = ST_GRANT;
                tmr_load_o = 1'b1;
            end
            ST_GRANT: begin
                if (grant_ack_i) begin
                    d.sr       = 1'b1;
                    d.st       = ST_SRIN;
                    tmr_load_o = 1'b1;
                end else if (tmr_expired_i) begin
                    d.err = 1'b1;
                end
            end
            ST_SRIN: begin
                if (sr_ack_i) begin
                    d.mload = 1'b1;
                    d.mlev  = q.tgt;
                    d.st    = ST_LOAD;
                end else if (tmr_expired_i) begin
                    d.err = 1'b1;
                end
            end
            ST_LOAD: begin
                d.clkstop  = 1'b1;
                d.st       = ST_STOP;
                tmr_load_o = 1'b1;
                tmr_us_o   = relock_us;
            end
            ST_STOP: if (tmr_expired_i) begin
                d.clkstop = 1'b0;
                d.st      = ST_RESUME;
            end
            ST_RESUME: begin
                d.sr       = 1'b0;
                d.st       = ST_SROUT;
                tmr_load_o = 1'b1;
            end
            ST_SROUT: begin
                if (!sr_ack_i) begin
                    d.fgrant   = 1'b0;
                    d.st       = ST_REL;
                    tmr_load_o = 1'b1;
                end else if (tmr_expired_i) begin
                    d.err = 1'b1;
                end
            end
            ST_REL: begin
                if (!grant_ack_i) begin
                    if (q.tgt < q.cur) begin
                        d.vreg     = q.tgt;
                        d.st       = ST_VDN;
                        tmr_load_o = 1'b1;
                        tmr_us_o   = cfg_settle_us_i;
                    end else begin
                        d.st   = ST_IDLE;
                        d.busy = 1'b0;
                        d.done = 1'b1;
                        d.cur  = q.tgt;
                    end
                end else if (tmr_expired_i) begin
                    d.err = 1'b1;
                end
            end
            ST_VDN: if (tmr_expired_i) begin
                d.st   = ST_IDLE;
                d.busy = 1'b0;
                d.done = 1'b1;
                d.cur  = q.tgt;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign flush_o   = q.flush;
    assign fgrant_o  = q.fgrant;
    assign sr_o      = q.sr;
    assign mload_o   = q.mload;
    assign mlev_o    = q.mlev;
    assign clkstop_o = q.clkstop;
    assign vreg_o    = q.vreg;
    assign cur_o     = q.cur;
    assign busy_o    = q.busy;
    assign done_o    = q.done;
    assign err_o     = q.err;

    // cycles spent with clocks stopped, for the relock floor check
    logic [31:0] stop_cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         stop_cnt_q <= '0;
        else if (q.clkstop) stop_cnt_q <= stop_cnt_q + 1'b1;
        else                stop_cnt_q <= '0;
    end

    a_r4_relock_floor: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.clkstop) |-> stop_cnt_q >= 32'(MIN_RELOCK_US * TICKS_PER_US));

    a_r8_volt_covers_freq: assert property (@(posedge clk) disable iff (!rst_n)
        q.vreg >= q.mlev);

    a_r3_stop_needs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        q.clkstop |-> (q.sr && q.fgrant));

    a_r3_sr_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        q.sr |-> q.fgrant);

    a_r3_load_in_refresh: assert property (@(posedge clk) disable iff (!rst_n)
        q.mload |-> (q.sr && !q.clkstop));

    a_r5_done_released: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> (!q.busy && !q.fgrant && !q.sr));

    a_r5_level_moves_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.cur) |-> q.done);

    a_r10_target_held: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |=> $stable(q.tgt));

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !q.busy |-> (!q.flush && !q.clkstop && !q.fgrant));

endmodule

// File: rtl/dvfs_seq.sv
module dvfs_seq #(
    parameter int NUM_LEVELS    = 8,
    parameter int TICKS_PER_US  = 50,
    parameter int US_W          = 16,
    parameter int MIN_RELOCK_US = 10,
    parameter int HS_MAX_US     = 2,
    localparam int LVL_W        = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [LVL_W-1:0] req_level,
    input  logic [US_W-1:0]  cfg_relock_us,
    input  logic [US_W-1:0]  cfg_settle_us,
    output logic             wr_flush_req,
    input  logic             wr_flush_ack,
    output logic             force_grant,
    input  logic             grant_ack,
    output logic             self_refresh,
    input  logic             sr_ack,
    output logic             mult_load,
    output logic [LVL_W-1:0] mult_level,
    output logic             clk_stop,
    output logic [LVL_W-1:0] vreg_level,
    output logic [LVL_W-1:0] cur_level,
    output logic             busy,
    output logic             done,
    output logic             hs_error
);
    logic            tmr_load;
    logic [US_W-1:0] tmr_us;
    logic            tmr_expired;

    dvfs_timer #(
        .TICKS_PER_US (TICKS_PER_US),
        .US_W         (US_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .load_us_i (tmr_us),
        .expired_o (tmr_expired)
    );

    dvfs_ctrl #(
        .LVL_W         (LVL_W),
        .US_W          (US_W),
        .TICKS_PER_US  (TICKS_PER_US),
        .MIN_RELOCK_US (MIN_RELOCK_US),
        .HS_MAX_US     (HS_MAX_US)
    ) u_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_valid_i     (req_valid),
        .req_level_i     (req_level),
        .cfg_relock_us_i (cfg_relock_us),
        .cfg_settle_us_i (cfg_settle_us),
        .flush_ack_i     (wr_flush_ack),
        .grant_ack_i     (grant_ack),
        .sr_ack_i        (sr_ack),
        .tmr_expired_i   (tmr_expired),
        .tmr_load_o      (tmr_load),
        .tmr_us_o        (tmr_us),
        .flush_o         (wr_flush_req),
        .fgrant_o        (force_grant),
        .sr_o            (self_refresh),
        .mload_o         (mult_load),
        .mlev_o          (mult_level),
        .clkstop_o       (clk_stop),
        .vreg_o          (vreg_level),
        .cur_o           (cur_level),
        .busy_o          (busy),
        .done_o          (done),
        .err_o           (hs_error)
    );

endmodule

// File: tb/sim_dvfs_seq.sv
module sim_dvfs_seq;
    localparam int TPU = 2;
    localparam int MINR = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [2:0] req_level = '0;
    logic [15:0] cfg_relock_us = 16'd10;
    logic [15:0] cfg_settle_us = 16'd4;
    logic wr_flush_req, force_grant, self_refresh, mult_load, clk_stop, busy, done, hs_error;
    logic wr_flush_ack = 1'b0, grant_ack = 1'b0, sr_ack = 1'b0;
    logic [2:0] mult_level, vreg_level, cur_level;

    always #10 clk = ~clk;

    dvfs_seq #(.TICKS_PER_US(TPU), .MIN_RELOCK_US(MINR), .HS_MAX_US(2)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_level(req_level),
        .cfg_relock_us(cfg_relock_us), .cfg_settle_us(cfg_settle_us),
        .wr_flush_req(wr_flush_req), .wr_flush_ack(wr_flush_ack),
        .force_grant(force_grant), .grant_ack(grant_ack),
        .self_refresh(self_refresh), .sr_ack(sr_ack),
        .mult_load(mult_load), .mult_level(mult_level), .clk_stop(clk_stop),
        .vreg_level(vreg_level), .cur_level(cur_level),
        .busy(busy), .done(done), .hs_error(hs_error));

    int n_chk = 0, n_fail = 0;
    int fdel = 3, gdel = 2, sdel = 2;
    int cyc = 0;
    int t_flush, t_fack, t_fg, t_gack, t_sr, t_srack, t_load, t_cs;
    int t_cs_f, t_sr_f, t_srack_f, t_fg_f, t_gack_f, t_done, t_vreg;
    int load_lvl, done_cnt, busy_seen, flush_seen, fg_seen, vbad;
    logic [2:0] vreg_start;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_win(input string req, input int act, input int lo);
        check(act >= lo && act <= lo + 2, req, act, lo);
    endtask

    task automatic clear_mon();
        t_flush = -1; t_fack = -1; t_fg = -1; t_gack = -1; t_sr = -1; t_srack = -1;
        t_load = -1; t_cs = -1; t_cs_f = -1; t_sr_f = -1; t_srack_f = -1;
        t_fg_f = -1; t_gack_f = -1; t_done = -1; t_vreg = -1;
        load_lvl = -1; done_cnt = 0; busy_seen = 0; flush_seen = 0; fg_seen = 0; vbad = 0;
        vreg_start = vreg_level;
    endtask

    // acknowledge responders
    initial begin
        int fc = 0, gc = 0, sc = 0;
        forever begin
            @(negedge clk);
            if (wr_flush_req && !wr_flush_ack) begin
                fc++;
                if (fc >= fdel) begin wr_flush_ack = 1'b1; fc = 0; end
            end else begin
                fc = 0;
                if (!wr_flush_req) wr_flush_ack = 1'b0;
            end
            if (grant_ack != force_grant) begin
                gc++;
                if (gc >= gdel) begin grant_ack = force_grant; gc = 0; end
            end else gc = 0;
            if (sr_ack != self_refresh) begin
                sc++;
                if (sc >= sdel) begin sr_ack = self_refresh; sc = 0; end
            end else sc = 0;
        end
    end

    // event monitor
    initial begin
        clear_mon();
        forever begin
            @(negedge clk);
            cyc++;
            if (wr_flush_req && t_flush < 0) t_flush = cyc;
            if (wr_flush_ack && t_fack < 0) t_fack = cyc;
            if (force_grant && t_fg < 0) t_fg = cyc;
            if (grant_ack && t_gack < 0) t_gack = cyc;
            if (self_refresh && t_sr < 0) t_sr = cyc;
            if (sr_ack && t_srack < 0) t_srack = cyc;
            if (mult_load && t_load < 0) begin t_load = cyc; load_lvl = int'(mult_level); end
            if (clk_stop && t_cs < 0) t_cs = cyc;
            if (!clk_stop && t_cs >= 0 && t_cs_f < 0) t_cs_f = cyc;
            if (!self_refresh && t_sr >= 0 && t_sr_f < 0) t_sr_f = cyc;
            if (!sr_ack && t_srack >= 0 && t_srack_f < 0) t_srack_f = cyc;
            if (!force_grant && t_fg >= 0 && t_fg_f < 0) t_fg_f = cyc;
            if (!grant_ack && t_gack >= 0 && t_gack_f < 0) t_gack_f = cyc;
            if (done) begin done_cnt++; if (t_done < 0) t_done = cyc; end
            if (vreg_level != vreg_start && t_vreg < 0) t_vreg = cyc;
            if (busy) busy_seen = 1;
            if (wr_flush_req) flush_seen = 1;
            if (force_grant) fg_seen = 1;
            if (vreg_level < mult_level) vbad = 1;
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    task automatic do_req(input int lvl);
        @(negedge clk);
        req_valid = 1'b1;
        req_level = 3'(lvl);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (t_done < 0 && n < 5000) begin
            @(negedge clk); #1; n++;
        end
        repeat (3) @(negedge clk);
        #1;
    endtask

    task automatic start_change(input int lvl, input int relock, input int settle);
        @(negedge clk);
        cfg_relock_us = 16'(relock);
        cfg_settle_us = 16'(settle);
        clear_mon();
        do_req(lvl);
    endtask

    task automatic check_core(input int lvl, input int relock);
        int eff = (relock < MINR) ? MINR : relock;
        check(t_done > 0, "R5 done seen", t_done, 1);
        check(t_fack > t_flush && t_fg > t_fack, "R3 flush before grant", t_fg, t_fack + 1);
        check(t_sr > t_gack && t_gack > t_fg, "R3 refresh after grant ack", t_sr, t_gack + 1);
        check(t_load > t_srack && load_lvl == lvl, "R3 multiplier load level", load_lvl, lvl);
        check(t_cs > t_load, "R3 clock stop after load", t_cs, t_load + 1);
        check_win("R4 relock window", t_cs_f - t_cs, eff * TPU);
        check(t_sr_f > t_cs_f && t_fg_f > t_srack_f, "R5 refresh exit before release", t_fg_f, t_srack_f + 1);
        check(t_done > t_gack_f, "R5 done after release ack", t_done, t_gack_f + 1);
        check(int'(cur_level) == lvl && !busy, "R5 level adopted", int'(cur_level), lvl);
        check(vbad == 0, "R8 voltage covers frequency", vbad, 0);
    endtask

    task automatic t_reset();
        check(cur_level == 0 && mult_level == 0 && vreg_level == 0, "R1 levels zero",
              int'(cur_level) + int'(mult_level) + int'(vreg_level), 0);
        check(!clk_stop && !force_grant && !self_refresh && !wr_flush_req, "R1 outputs idle",
              int'(clk_stop) + int'(force_grant) + int'(self_refresh) + int'(wr_flush_req), 0);
        check(!busy && !done && !hs_error, "R1 status low",
              int'(busy) + int'(done) + int'(hs_error), 0);
    endtask

    task automatic t_raise();
        start_change(5, 3, 4);
        wait_done();
        check_core(5, 3);
        check(t_vreg > 0 && t_vreg < t_flush, "R6 voltage first", t_vreg, t_flush - 1);
        check_win("R6 settle before flush", t_flush - t_vreg, 4 * TPU);
        check(hs_error == 0, "R9 no error within limit", int'(hs_error), 0);
    endtask

    task automatic t_same();
        @(negedge clk);
        clear_mon();
        do_req(5);
        repeat (2) @(negedge clk);
        #1;
        check(t_done > 0 && done_cnt == 1, "R2 immediate done", done_cnt, 1);
        check(busy_seen == 0 && flush_seen == 0 && fg_seen == 0, "R2 no sequence",
              busy_seen + flush_seen + fg_seen, 0);
    endtask

    task automatic t_lower();
        start_change(2, 15, 6);
        wait_done();
        check_core(2, 15);
        check(t_vreg > t_gack_f, "R7 voltage after release", t_vreg, t_gack_f + 1);
        check_win("R7 settle before done", t_done - t_vreg, 6 * TPU);
        check(int'(vreg_level) == 2, "R7 final voltage", int'(vreg_level), 2);
    endtask

    task automatic t_long_settle();
        start_change(7, 10, 256);
        wait_done();
        check_core(7, 10);
        check_win("R11 256 us settle", t_flush - t_vreg, 256 * TPU);
    endtask

    task automatic t_timeout();
        gdel = 8;
        start_change(1, 10, 2);
        wait_done();
        gdel = 2;
        check(int'(cur_level) == 1, "R9 completes after late ack", int'(cur_level), 1);
        check(hs_error == 1, "R9 late ack flags error", int'(hs_error), 1);
        start_change(3, 10, 2);
        wait_done();
        check(hs_error == 0 && int'(cur_level) == 3, "R9 error cleared by next change",
              int'(hs_error), 0);
    endtask

    task automatic t_busy_ignore();
        start_change(6, 10, 3);
        repeat (10) @(negedge clk);
        #1;
        check(busy == 1, "R10 busy during change", int'(busy), 1);
        do_req(0);
        wait_done();
        repeat (10) @(negedge clk);
        #1;
        check(int'(cur_level) == 6 && done_cnt == 1, "R10 late request ignored",
              int'(cur_level), 6);
        check(busy == 0 && int'(vreg_level) == 6, "R10 idle at first target",
              int'(vreg_level), 6);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        t_reset();
        t_raise();
        t_same();
        t_lower();
        t_long_settle();
        t_timeout();
        t_busy_ignore();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule